// File: doc/BRIEF.md
# Stuck Interrupt Detector

This block watches the stream of accepted interrupt messages and flags a source that keeps firing in a tight loop. Each accepted message carries an identity made of the requester's bus/device/function number and a cause code. The block remembers the identities of recent messages, each tagged with the value of a free-running cycle counter taken when it was accepted. When a new message has the same identity as the oldest message in the window, and little time has passed between the two, that source is reported as stuck.

The window spans `DEPTH` messages: the `DEPTH-1` stored in a shift history plus the one arriving now. Cycles with no message do not move the history. Time is measured with modular subtraction on a `TS_W`-bit counter, so counter wraparound gives no false gap. The report is a one-cycle pulse with the offending identity. The identity stays on the outputs until the next report. A source already reported is not reported again until some other identity has been accepted.

Control is a three-state machine. `ST_FILL` (after reset) counts accepted messages until the window is full. `ST_WATCH` is armed and compares every message. `ST_HOLD` follows a report and suppresses repeats of the reported identity. The transitions are:
- fill-done: `ST_FILL` to `ST_WATCH`
- fill-hit: `ST_FILL` to `ST_HOLD`, when the message that fills the window is already stuck
- hit: `ST_WATCH` to `ST_HOLD`
- release: `ST_HOLD` to `ST_WATCH`, when a different identity arrives and is not itself stuck
- re-hit: `ST_HOLD` to `ST_HOLD`, when a different identity is stuck

Top module: `stuck_irq_detect`

## Requirements
- R1: While reset is held and in the first cycle after it, `stuck_pulse` is 0 and `stuck_bdf`/`stuck_cause` are 0.
- R2: No report is made until `DEPTH` (default 8) messages have been accepted since reset: the first `DEPTH-1` accepts never pulse.
- R3: A report is made when the accepted message's identity equals that of the message accepted `DEPTH-1` accepts earlier, and `(t_new - t_old) mod 2^TS_W < threshold`. Here t is the cycle counter value at the accepting edge. `stuck_pulse` is high for exactly the one cycle after that edge.
- R4: The comparison is strict: a difference equal to `threshold`, or larger, gives no report.
- R5: The identity is the full pair {`msg_bdf`, `msg_cause`}: a message that differs in only the cause, or in only the bus/device/function, does not match.
- R6: Differences are taken modulo 2^`TS_W`, so a true gap of 2^`TS_W` + d cycles counts as d.
- R7: After a report, further messages with the same identity are not reported until a message with a different identity has been accepted. After that, the same identity may be reported again.
- R8: `stuck_bdf`/`stuck_cause` load the reported identity in the pulse cycle and hold it until the next report.
- R9: Cycles with `msg_valid` low neither enter the history nor count toward filling it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | An interrupt message is accepted this cycle |
| msg_bdf | input | 16 | Requester bus/device/function of the message |
| msg_cause | input | 8 | Cause code of the message |
| threshold | input | TS_W | Largest gap, exclusive, in cycles, still judged stuck |
| stuck_pulse | output | 1 | One-cycle report of a stuck source |
| stuck_bdf | output | 16 | Bus/device/function of the last reported source |
| stuck_cause | output | 8 | Cause code of the last reported source |

## Verification
Every result here is due one clock after the edge that accepts the message: the pulse and the reported identity are registered outputs. Idle cycles only stretch the timestamp gap. A behavioural model in the bench, built on a queue of (identity, cycle) pairs, produces the expected pulse and identity at each rising edge. The outputs are compared against it a quarter period after every edge. Directed scenarios additionally read the pulse on the falling edge that ends the accepting cycle. Timing corners are set exactly with known idle gaps: a difference equal to the threshold, one below it, and a gap past the counter's wrap using a narrow counter.

// File: rtl/stuck_irq_pkg.sv
package stuck_irq_pkg;

    localparam int BDF_W   = 16;
    localparam int CAUSE_W = 8;
    localparam int ID_W    = BDF_W + CAUSE_W;

    typedef struct packed {
        logic [BDF_W-1:0]   bdf;
        logic [CAUSE_W-1:0] cause;
    } src_id_t;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_WATCH = 2'd1,
        ST_HOLD  = 2'd2
    } det_state_e;

endpackage

// File: rtl/stuck_irq_tstamp.sv
module stuck_irq_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_now
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_now <= '0;
        end else begin
            ts_now <= ts_now + 1'b1;
        end
    end

endmodule

// File: rtl/stuck_irq_history.sv
module stuck_irq_history
    import stuck_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TS_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  src_id_t         in_id,
    input  logic [TS_W-1:0] in_ts,
    output src_id_t         old_id,
    output logic [TS_W-1:0] old_ts
);

    // The arriving message is the newest member of the window, so only
    // the DEPTH-1 earlier ones need storage.
    localparam int SLOTS = DEPTH - 1;

    src_id_t         id_q [SLOTS];
    logic [TS_W-1:0] ts_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    id_q[g] <= '0;
                    ts_q[g] <= '0;
                end else if (push) begin
                    id_q[g] <= in_id;
                    ts_q[g] <= in_ts;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    id_q[g] <= '0;
                    ts_q[g] <= '0;
                end else if (push) begin
                    id_q[g] <= id_q[g-1];
                    ts_q[g] <= ts_q[g-1];
                end
            end
        end
    end

    assign old_id = id_q[SLOTS-1];
    assign old_ts = ts_q[SLOTS-1];

endmodule

// File: rtl/stuck_irq_match.sv
module stuck_irq_match
    import stuck_irq_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  src_id_t         new_id,
    input  logic [TS_W-1:0] new_ts,
    input  src_id_t         old_id,
    input  logic [TS_W-1:0] old_ts,
    input  logic [TS_W-1:0] limit,
    output logic            same_src,
    output logic            close_in_time
);

    logic [TS_W-1:0] gap;

    // Modular difference: correct across one counter wrap.
    assign gap           = new_ts - old_ts;
    assign close_in_time = (gap < limit);
    assign same_src      = (new_id == old_id);

endmodule

// File: rtl/stuck_irq_detect.sv
module stuck_irq_detect
    import stuck_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TS_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic [BDF_W-1:0]   msg_bdf,
    input  logic [CAUSE_W-1:0] msg_cause,
    input  logic [TS_W-1:0]    threshold,
    output logic               stuck_pulse,
    output logic [BDF_W-1:0]   stuck_bdf,
    output logic [CAUSE_W-1:0] stuck_cause
);

    localparam int               FILL_W   = $clog2(DEPTH);
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(DEPTH - 1);

    det_state_e        state, state_nx;
    logic [FILL_W-1:0] fill_cnt;
    logic [TS_W-1:0]   ts_now;
    logic [TS_W-1:0]   old_ts;
    src_id_t           in_id;
    src_id_t           old_id;
    src_id_t           last_id;
    logic              same_src;
    logic              close_in_time;
    logic              window_full;
    logic              repeat_src;
    logic              fire;

    assign in_id   = '{bdf: msg_bdf, cause: msg_cause};
    assign last_id = '{bdf: stuck_bdf, cause: stuck_cause};

    stuck_irq_tstamp #(.TS_W(TS_W)) u_tstamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .ts_now (ts_now)
    );

    stuck_irq_history #(.DEPTH(DEPTH), .TS_W(TS_W)) u_history (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (msg_valid),
        .in_id  (in_id),
        .in_ts  (ts_now),
        .old_id (old_id),
        .old_ts (old_ts)
    );

    stuck_irq_match #(.TS_W(TS_W)) u_match (
        .new_id        (in_id),
        .new_ts        (ts_now),
        .old_id        (old_id),
        .old_ts        (old_ts),
        .limit         (threshold),
        .same_src      (same_src),
        .close_in_time (close_in_time)
    );

    assign window_full = (state != ST_FILL) || (fill_cnt == FULL_CNT);
    assign repeat_src  = (state == ST_HOLD) && (in_id == last_id);
    assign fire        = msg_valid && window_full && same_src &&
                         close_in_time && !repeat_src;

    // Fill counter: counts accepts until the window is complete.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (state == ST_FILL && msg_valid && fill_cnt != FULL_CNT) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: begin
                if (msg_valid && fill_cnt == FULL_CNT) begin
                    state_nx = fire ? ST_HOLD : ST_WATCH;   // fill-hit / fill-done
                end
            end
            ST_WATCH: begin
                if (fire) begin
                    state_nx = ST_HOLD;                      // hit
                end
            end
            ST_HOLD: begin
                if (msg_valid && !repeat_src && !fire) begin
                    state_nx = ST_WATCH;                     // release
                end
            end
            default: state_nx = ST_FILL;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stuck_pulse <= 1'b0;
            stuck_bdf   <= '0;
            stuck_cause <= '0;
        end else begin
            stuck_pulse <= fire;
            if (fire) begin
                stuck_bdf   <= msg_bdf;
                stuck_cause <= msg_cause;
            end
        end
    end

endmodule

// File: rtl/stuck_irq_detect_chk.sv
module stuck_irq_detect_chk
    import stuck_irq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic [BDF_W-1:0]   msg_bdf,
    input logic [CAUSE_W-1:0] msg_cause,
    input logic               stuck_pulse,
    input logic [BDF_W-1:0]   stuck_bdf,
    input logic [CAUSE_W-1:0] stuck_cause
);

    localparam int ACC_W = $clog2(DEPTH + 1);

    logic [ACC_W-1:0] acc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (msg_valid && acc_cnt != ACC_W'(DEPTH)) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    // R2
    window_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_pulse |-> acc_cnt == ACC_W'(DEPTH));

    // R3
    pulse_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_pulse |-> $past(msg_valid));

    // R8
    id_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_pulse |-> {stuck_bdf, stuck_cause} == $past({msg_bdf, msg_cause}));

    // R8
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stuck_pulse |-> $stable({stuck_bdf, stuck_cause}));

    // R7
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_pulse |=> !(stuck_pulse && $stable({stuck_bdf, stuck_cause})));

endmodule

bind stuck_irq_detect stuck_irq_detect_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_bdf     (msg_bdf),
    .msg_cause   (msg_cause),
    .stuck_pulse (stuck_pulse),
    .stuck_bdf   (stuck_bdf),
    .stuck_cause (stuck_cause)
);

// File: tb/stuck_irq_detect_test.sv
module stuck_irq_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int TS_W       = 10;
    localparam int MOD        = 1 << TS_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            msg_valid = 1'b0;
    logic [15:0]     msg_bdf = '0;
    logic [7:0]      msg_cause = '0;
    logic [TS_W-1:0] threshold = '0;
    logic            stuck_pulse;
    logic [15:0]     stuck_bdf;
    logic [7:0]      stuck_cause;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    typedef struct { int id; int ts; } ent_t;
    ent_t hist[$];
    int   cyc = 0;
    bit   quiet = 0;
    int   quiet_id = 0;
    bit   exp_pulse = 0;
    int   exp_id = 0;

    localparam logic [23:0] ID_A = 24'h1A2B_03;
    localparam logic [23:0] ID_B = 24'h0C10_07;
    localparam logic [23:0] ID_C = 24'h1A2B_04;
    localparam logic [23:0] ID_D = 24'h1A2C_03;

    stuck_irq_detect #(.DEPTH(DEPTH), .TS_W(TS_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .msg_valid   (msg_valid),
        .msg_bdf     (msg_bdf),
        .msg_cause   (msg_cause),
        .threshold   (threshold),
        .stuck_pulse (stuck_pulse),
        .stuck_bdf   (stuck_bdf),
        .stuck_cause (stuck_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: queue of (identity, cycle) pairs
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            cyc = 0; quiet = 0; quiet_id = 0; exp_pulse = 0; exp_id = 0;
        end else begin
            exp_pulse = 0;
            if (msg_valid) begin
                int  id;
                bit  hit;
                id  = int'({msg_bdf, msg_cause});
                hist.push_back('{id: id, ts: cyc});
                if (hist.size() > DEPTH) void'(hist.pop_front());
                hit = 0;
                if (hist.size() == DEPTH)
                    hit = (hist[0].id == id) && (((cyc - hist[0].ts) % MOD) < int'(threshold));
                if (quiet && id == quiet_id) hit = 0;
                if (hit) begin
                    exp_pulse = 1; exp_id = id; quiet = 1; quiet_id = id;
                end else if (quiet && id != quiet_id) begin
                    quiet = 0;
                end
            end
            cyc++;
        end
    end

    // Per-cycle comparison a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!done) begin
            chk(stuck_pulse === exp_pulse, {cur_req, " model pulse"},
                int'(stuck_pulse), int'(exp_pulse));
            chk({stuck_bdf, stuck_cause} === 24'(exp_id), {cur_req, " model id"},
                int'({stuck_bdf, stuck_cause}), exp_id);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; msg_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [23:0] id);
        {msg_bdf, msg_cause} = id;
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulse(input bit e, input string req);
        chk(stuck_pulse === e, req, int'(stuck_pulse), int'(e));
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        cur_req = "R1";
        expect_pulse(1'b0, "R1 pulse after reset");
        chk({stuck_bdf, stuck_cause} === 24'h0, "R1 id after reset",
            int'({stuck_bdf, stuck_cause}), 0);

        // R2 / R3 / R7 / R8
        cur_req = "R2";
        threshold = 10'd1000;
        for (int i = 0; i < DEPTH - 1; i++) begin
            send(ID_A);
            expect_pulse(1'b0, "R2 no report while filling");
        end
        cur_req = "R3";
        send(ID_A);
        expect_pulse(1'b1, "R3 report on filling message");
        chk({stuck_bdf, stuck_cause} === ID_A, "R8 reported id",
            int'({stuck_bdf, stuck_cause}), int'(ID_A));
        cur_req = "R7";
        send(ID_A);
        expect_pulse(1'b0, "R7 same id suppressed");
        send(ID_B);
        expect_pulse(1'b0, "R7 other id no match");
        chk({stuck_bdf, stuck_cause} === ID_A, "R8 id held",
            int'({stuck_bdf, stuck_cause}), int'(ID_A));
        send(ID_A);
        expect_pulse(1'b1, "R7 re-report after other id");

        // R4: strict threshold, spacing 3 cycles -> gap 21
        cur_req = "R4";
        do_reset();
        threshold = 10'd21;
        for (int i = 0; i < DEPTH; i++) begin
            send(ID_A);
            if (i < DEPTH - 1) idle(2);
        end
        expect_pulse(1'b0, "R4 gap equal to threshold");
        do_reset();
        threshold = 10'd22;
        for (int i = 0; i < DEPTH; i++) begin
            send(ID_A);
            if (i < DEPTH - 1) idle(2);
        end
        expect_pulse(1'b1, "R4 gap one below threshold");

        // R5: full identity compare
        cur_req = "R5";
        do_reset();
        threshold = 10'd1000;
        for (int i = 0; i < DEPTH - 1; i++) send(ID_A);
        send(ID_C);
        expect_pulse(1'b0, "R5 cause differs");
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) send(ID_A);
        send(ID_D);
        expect_pulse(1'b0, "R5 bdf differs");

        // R6: modular gap, 1037 cycles -> 13
        cur_req = "R6";
        do_reset();
        threshold = 10'd50;
        send(ID_A);
        idle(1030);
        for (int i = 0; i < DEPTH - 1; i++) send(ID_A);
        expect_pulse(1'b1, "R6 wrapped gap 13 < 50");
        do_reset();
        send(ID_A);
        idle(1100);
        for (int i = 0; i < DEPTH - 1; i++) send(ID_A);
        expect_pulse(1'b0, "R6 wrapped gap 83 >= 50");

        // R9: idle cycles do not shift the history; gap 27
        cur_req = "R9";
        do_reset();
        threshold = 10'd100;
        send(ID_A);
        idle(20);
        for (int i = 0; i < DEPTH - 1; i++) send(ID_A);
        expect_pulse(1'b1, "R9 idle gap not recorded");

        // Mixed traffic against the model (R3, R7, R8)
        cur_req = "R3/R7 mixed";
        do_reset();
        for (int blk = 0; blk < 40; blk++) begin
            threshold = 10'(5 + ($urandom % 56));
            for (int m = 0; m < 50; m++) begin
                int pick;
                pick = int'($urandom % 3);
                send(pick == 0 ? ID_A : (pick == 1 ? ID_B : ID_C));
                idle(int'($urandom % 4));
            end
        end
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog (%s): actual timeout expected completion", cur_req);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule